// File: doc/BRIEF.md
# Multichannel Acquisition Sequencer Controller

This block is the digital control for an eight-input acquisition front end. For every conversion it picks the multiplexer channel and the front-end settings: differential or single-ended, unipolar or bipolar span, and gain. It drives these to the analog side and tags each finished result with the settings that produced it. A simple conversion-done input stands in for the converter core. The analog multiplexer, the converter and power management are not part of this block.

A two-bit mode input selects one of four ways of working.

- **Direct** (`00`): the configuration inputs either flow straight through while the write strobe is low, or are captured on its rising edge.
- **Scan** (`01`): the block steps through the eight channels, one per conversion.
- **Program/readback** (`10`): the write strobe fills a 16-entry sequence memory, and the read strobe walks through the stored words one at a time. The busy line is held low for the whole stay in this mode.
- **Sequence** (`11`): conversions take their settings from the stored entries in order. After an entry flagged as end-of-sequence, the next conversion returns to entry 0.

All strobes are sampled on the system clock. Edges are found by comparing each strobe with its value one cycle earlier.

Top module: `mux_seq_ctrl`

## Requirements
- R1: After reset, busyN is 1, activeCfg is 0, resTag is 0, rbData is 0, the scan channel is 0 and the location counter is 0.
- R2: In mode 00, a conversion started while wrN is low uses the live cfgIn. A rising edge of wrN captures cfgIn, and while wrN stays high, later cfgIn changes do not reach the next conversion.
- R3: A conversion starts only on a high-to-low change of convStN sampled while csN is low. busyN is 0 from the clock edge that sees the fall until the edge that sees convDone high. A second fall during a conversion is ignored.
- R4: In mode 01, the conversion address is the scan channel and the other settings come from the direct latch. The channel advances by one on each completed conversion and wraps from 7 to 0.
- R5: In mode 10, each rising edge of wrN stores cfgIn at the current location and advances the location. The location wraps from 15 to 0.
- R6: In mode 10, while rdN and csN are both low, rbData shows the stored word at the current location. A rising edge of rdN with csN low advances the location. At all other times rbData is 0.
- R7: busyN is 0 from the clock edge after modeSel becomes 10 for as long as it stays 10. It returns to 1 one edge after leaving, unless a conversion is running.
- R8: The location counter returns to 0 on the edge where modeSel changes to 10 or to 11.
- R9: In mode 11, a conversion uses the entry at the current location, and the location advances only when the conversion completes. After an entry whose end-of-sequence bit is set, or after entry 15, the next entry is 0.
- R10: One edge after convDone is sampled high during a conversion, resTag equals {diff, addr} of the configuration used. activeCfg keeps showing that configuration until the next conversion starts.
- R11: In mode 10, falls of convStN start no conversion.

Word layout: bits [2:0] are the channel address, bit 3 selects differential, bit 4 selects bipolar, bit 5 is gain select, and bit 6 (stored words only) is end-of-sequence. activeCfg carries bits [5:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Mode: 00 direct, 01 scan, 10 program/readback, 11 sequence |
| csN | input | 1 | Active-low chip select, gates convStN and rdN |
| wrN | input | 1 | Active-low write strobe, acts on its rising edge |
| rdN | input | 1 | Active-low read strobe for readback |
| convStN | input | 1 | Active-low conversion start, acts on its falling edge |
| convDone | input | 1 | Converter finished, one-cycle pulse |
| cfgIn | input | 7 | Configuration word input (layout above) |
| busyN | output | 1 | Low while converting or in mode 10 |
| activeCfg | output | 6 | Configuration of the current or last conversion |
| resTag | output | 4 | {diff, addr} of the last completed result |
| rbData | output | 7 | Stored word during readback, 0 otherwise |

## Verification
Registered results appear one edge after the sampled event: busyN one edge after the convStN fall or the mode change, resTag and the next scan channel or sequence location one edge after convDone, and the cleared location one edge after the mode change. rbData is combinational and valid as soon as rdN is low. The bench drives on falling clock edges and samples on the following falling edge, so each check lands half a cycle after the edge that produces the value. Conversion results are popped from an expected-item queue at the first falling edge after the convDone edge.

// File: rtl/seq_ctrl_pkg.sv
package seq_ctrl_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'b00,
    MODE_SCAN   = 2'b01,
    MODE_PROG   = 2'b10,
    MODE_SEQ    = 2'b11
  } modeT;

  // bit 6 eos, 5 gain, 4 bipolar, 3 diff, 2:0 channel address
  typedef struct packed {
    logic              eos;
    logic              gain;
    logic              uniBip;
    logic              diff;
    logic [ADDR_W-1:0] addr;
  } cfgWordT;

  typedef struct packed {
    logic locClr;
    logic memWr;
    logic locInc;
    logic dirLatch;
    logic wrPass;
    logic convLatch;
    logic convFinish;
    logic rbEn;
    modeT mode;
  } strobeT;

endpackage

// File: rtl/seq_ctrl_ctl.sv
module seq_ctrl_ctl
  import seq_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       csN,
  input  logic       wrN,
  input  logic       rdN,
  input  logic       convStN,
  input  logic       convDone,
  output strobeT     stb,
  output logic       busyN
);

  logic wrNq, rdNq, convStNq;
  modeT modePrev;
  modeT mode;
  logic converting, convNext;
  logic busyQ;
  logic progMode;
  logic wrRise, rdRise, convFall;

  assign mode     = modeT'(modeSel);
  assign progMode = (mode == MODE_PROG);
  assign wrRise   = wrN & ~wrNq;
  assign rdRise   = rdN & ~rdNq & ~csN;
  assign convFall = ~convStN & convStNq & ~csN;

  always_comb begin
    stb            = '0;
    stb.mode       = mode;
    stb.locClr     = (mode != modePrev) && (mode == MODE_PROG || mode == MODE_SEQ);
    stb.memWr      = progMode & wrRise;
    stb.locInc     = progMode & (wrRise | rdRise);
    stb.dirLatch   = wrRise & (mode == MODE_DIRECT || mode == MODE_SCAN);
    stb.wrPass     = ~wrN & (mode == MODE_DIRECT);
    stb.convLatch  = convFall & ~progMode & ~converting;
    stb.convFinish = convDone & converting;
    stb.rbEn       = progMode & ~rdN & ~csN;
  end

  always_comb begin
    convNext = converting;
    if (stb.convLatch)       convNext = 1'b1;
    else if (stb.convFinish) convNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrNq       <= 1'b1;
      rdNq       <= 1'b1;
      convStNq   <= 1'b1;
      modePrev   <= MODE_DIRECT;
      converting <= 1'b0;
      busyQ      <= 1'b1;
    end else begin
      wrNq       <= wrN;
      rdNq       <= rdN;
      convStNq   <= convStN;
      modePrev   <= mode;
      converting <= convNext;
      busyQ      <= ~(convNext | progMode);
    end
  end

  assign busyN = busyQ;

  // R3
  conv_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !convStN && convStNq && !progMode && !converting) |=> (converting && !busyN));

  // R3
  conv_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (converting && !convDone) |=> converting);

  // R11
  prog_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (progMode && !converting) |=> !converting);

  // R7
  prog_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    progMode |=> !busyN);

endmodule

// File: rtl/seq_ctrl_dp.sv
module seq_ctrl_dp
  import seq_ctrl_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int CHANNELS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobeT     stb,
  input  logic [6:0] cfgIn,
  output logic [5:0] activeCfg,
  output logic [3:0] resTag,
  output logic [6:0] rbData
);

  localparam int LOC_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CH_W  = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;
  localparam logic [LOC_W-1:0] LOC_LAST = LOC_W'(DEPTH - 1);
  localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(CHANNELS - 1);

  cfgWordT          mem [DEPTH];
  cfgWordT          dirReg, convCfg, selCfg, inWord, curEntry;
  logic [LOC_W-1:0] loc, locNext;
  logic [CH_W-1:0]  scanCh;
  logic [3:0]       tagQ;

  assign inWord   = cfgWordT'(cfgIn);
  assign curEntry = mem[loc];

  always_comb begin
    selCfg = dirReg;
    case (stb.mode)
      MODE_DIRECT: selCfg = stb.wrPass ? inWord : dirReg;
      MODE_SCAN: begin
        selCfg      = dirReg;
        selCfg.addr = ADDR_W'(scanCh);
      end
      MODE_SEQ:    selCfg = curEntry;
      default:     selCfg = dirReg;
    endcase
    selCfg.eos = 1'b0;
  end

  always_comb begin
    locNext = loc;
    if (stb.locClr)
      locNext = '0;
    else if (stb.locInc)
      locNext = (loc == LOC_LAST) ? '0 : loc + LOC_W'(1);
    else if (stb.convFinish && stb.mode == MODE_SEQ)
      locNext = (curEntry.eos || loc == LOC_LAST) ? '0 : loc + LOC_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
    end else if (stb.memWr) begin
      mem[loc] <= inWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loc     <= '0;
      scanCh  <= '0;
      dirReg  <= '0;
      convCfg <= '0;
      tagQ    <= '0;
    end else begin
      loc <= locNext;
      if (stb.dirLatch)  dirReg  <= inWord;
      if (stb.convLatch) convCfg <= selCfg;
      if (stb.convFinish) begin
        tagQ <= {convCfg.diff, convCfg.addr};
        if (stb.mode == MODE_SCAN)
          scanCh <= (scanCh == CH_LAST) ? '0 : scanCh + CH_W'(1);
      end
    end
  end

  assign activeCfg = convCfg[5:0];
  assign resTag    = tagQ;
  assign rbData    = stb.rbEn ? curEntry : '0;

  // R8
  loc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.locClr |=> (loc == '0));

  // R5
  loc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.memWr && !stb.locClr && loc != LOC_LAST) |=> (loc == $past(loc) + LOC_W'(1)));

  // R10
  tag_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.convFinish |=> (resTag == {$past(convCfg.diff), $past(convCfg.addr)}));

  // R4
  scan_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.convFinish && stb.mode == MODE_SCAN && scanCh != CH_LAST)
      |=> (scanCh == $past(scanCh) + CH_W'(1)));

endmodule

// File: rtl/mux_seq_ctrl.sv
module mux_seq_ctrl
  import seq_ctrl_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int CHANNELS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       csN,
  input  logic       wrN,
  input  logic       rdN,
  input  logic       convStN,
  input  logic       convDone,
  input  logic [6:0] cfgIn,
  output logic       busyN,
  output logic [5:0] activeCfg,
  output logic [3:0] resTag,
  output logic [6:0] rbData
);

  strobeT stb;

  seq_ctrl_ctl ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .csN      (csN),
    .wrN      (wrN),
    .rdN      (rdN),
    .convStN  (convStN),
    .convDone (convDone),
    .stb      (stb),
    .busyN    (busyN)
  );

  seq_ctrl_dp #(
    .DEPTH    (DEPTH),
    .CHANNELS (CHANNELS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cfgIn     (cfgIn),
    .activeCfg (activeCfg),
    .resTag    (resTag),
    .rbData    (rbData)
  );

endmodule

// File: tb/mux_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mux_seq_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       csN = 1'b0;
  logic       wrN = 1'b1;
  logic       rdN = 1'b1;
  logic       convStN = 1'b1;
  logic       convDone = 1'b0;
  logic [6:0] cfgIn = '0;
  logic       busyN;
  logic [5:0] activeCfg;
  logic [3:0] resTag;
  logic [6:0] rbData;

  int nCmp = 0;
  int nBad = 0;
  logic finished = 1'b0;
  logic doneSeen = 1'b0;
  logic [5:0] expQ[$];
  logic [6:0] expMem [16];

  always #2 clk = ~clk;

  mux_seq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .csN(csN), .wrN(wrN), .rdN(rdN),
    .convStN(convStN), .convDone(convDone), .cfgIn(cfgIn), .busyN(busyN),
    .activeCfg(activeCfg), .resTag(resTag), .rbData(rbData)
  );

  task automatic chk(input string req, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: scoreboard pop on the falling edge after the convDone edge
  always @(posedge clk) doneSeen <= convDone;
  always @(negedge clk) begin
    if (doneSeen) begin
      if (expQ.size() == 0) begin
        chk("R10 unexpected result", 1, 0);
      end else begin
        logic [5:0] e;
        e = expQ.pop_front();
        chk("R10 activeCfg", int'(activeCfg), int'(e));
        chk("R10 resTag", int'(resTag), int'({e[3], e[2:0]}));
      end
    end
  end

  task automatic doConv(input logic [5:0] exp, input string req);
    expQ.push_back(exp);
    @(negedge clk) convStN = 1'b0;
    @(negedge clk) convStN = 1'b1;
    chk({req, " R3 busy low at start"}, int'(busyN), 0);
    repeat (2) @(negedge clk);
    chk({req, " R3 busy held"}, int'(busyN), 0);
    convDone = 1'b1;
    @(negedge clk) convDone = 1'b0;
    chk({req, " R3 busy released"}, int'(busyN), 1);
  endtask

  task automatic setMode(input logic [1:0] m);
    @(negedge clk) modeSel = m;
    @(negedge clk);
  endtask

  task automatic wrWord(input logic [6:0] w);
    @(negedge clk) begin cfgIn = w; wrN = 1'b0; end
    @(negedge clk) wrN = 1'b1;
    @(negedge clk);
  endtask

  task automatic rdWord(input logic [6:0] exp, input string req);
    @(negedge clk) rdN = 1'b0;
    @(negedge clk) chk(req, int'(rbData), int'(exp));
    rdN = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [6:0] val(input int k);
    return {(k == 2), 6'((k * 7 + 5) & 63)};
  endfunction

  initial begin
    #(4 * 200000);
    if (!finished) begin
      chk("watchdog expired", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [6:0] latched;
    logic [1:0] loc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busyN", int'(busyN), 1);
    chk("R1 activeCfg", int'(activeCfg), 0);
    chk("R1 resTag", int'(resTag), 0);
    chk("R1 rbData", int'(rbData), 0);

    // R2 pass-through with write held low
    @(negedge clk) begin wrN = 1'b0; cfgIn = 7'h2D; end
    doConv(6'h2D, "R2 passthrough");
    // R2 latch on write rise, later input change ignored
    @(negedge clk) cfgIn = 7'h1A;
    @(negedge clk) wrN = 1'b1;
    @(negedge clk) cfgIn = 7'h35;
    latched = 7'h1A;
    doConv(latched[5:0], "R2 latched");

    // R3 chip select high blocks start
    @(negedge clk) begin csN = 1'b1; convStN = 1'b0; end
    @(negedge clk) convStN = 1'b1;
    @(negedge clk) chk("R3 cs high no start", int'(busyN), 1);
    csN = 1'b0;
    // R3 second fall during a conversion ignored
    expQ.push_back(latched[5:0]);
    @(negedge clk) convStN = 1'b0;
    @(negedge clk) convStN = 1'b1;
    @(negedge clk) convStN = 1'b0;
    @(negedge clk) convStN = 1'b1;
    chk("R3 second fall busy", int'(busyN), 0);
    convDone = 1'b1;
    @(negedge clk) convDone = 1'b0;
    chk("R3 single conversion", int'(busyN), 1);
    repeat (2) @(negedge clk);
    chk("R3 no second result", int'(expQ.size()), 0);

    // R4 scan through channels with wrap
    setMode(2'b01);
    for (int i = 0; i < 9; i++) doConv({latched[5:3], 3'(i % 8)}, "R4 scan");

    // R7 busy in program mode, R11 start ignored
    setMode(2'b10);
    chk("R7 busy low in prog", int'(busyN), 0);
    @(negedge clk) convStN = 1'b0;
    @(negedge clk) convStN = 1'b1;
    @(negedge clk) chk("R11 activeCfg unchanged", int'(activeCfg), int'({latched[5:3], 3'd0}));
    // R5 program 17 words, last wraps onto entry 0
    for (int k = 0; k < 17; k++) begin
      wrWord(val(k));
      expMem[k % 16] = val(k);
    end
    setMode(2'b00);
    chk("R7 busy released R11 nothing pending", int'(busyN), 1);
    // R8 re-entry clears location, R6 readback
    setMode(2'b10);
    for (int k = 0; k < 4; k++) rdWord(expMem[k], "R6 R5 readback");
    @(negedge clk) begin csN = 1'b1; rdN = 1'b0; end
    @(negedge clk) chk("R6 cs high rbData zero", int'(rbData), 0);
    rdN = 1'b1;
    @(negedge clk) csN = 1'b0;
    @(negedge clk) chk("R6 rbData idle zero", int'(rbData), 0);
    rdWord(expMem[4], "R6 no advance with cs high");

    // R9 sequence with end flag on entry 2
    setMode(2'b11);
    loc = 0;
    for (int i = 0; i < 5; i++) begin
      doConv(expMem[loc][5:0], "R9 R8 seq eos");
      loc = (loc == 2) ? 2'd0 : loc + 2'd1;
    end

    // R9 clear the flag and run past entry 15
    setMode(2'b10);
    for (int k = 0; k < 3; k++) begin
      wrWord({1'b0, val(k + 20)[5:0]});
      expMem[k] = {1'b0, val(k + 20)[5:0]};
    end
    setMode(2'b11);
    for (int i = 0; i < 17; i++) doConv(expMem[i % 16][5:0], "R9 wrap at last");
    repeat (2) @(negedge clk);
    chk("R10 queue drained", int'(expQ.size()), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule